// File: doc/BRIEF.md
# Transmit Serializer with Remote Loopback

This block sits between a framer and the line side of a 155 Mbit/s class optical transmitter. It runs on the line-rate bit clock and turns framer data into a single NRZ bit stream. The framer can deliver a serial stream or a parallel word that is 4 or 8 bits wide, chosen at run time. The block drives the capture clock back to the framer. In serial mode this is the bit clock itself. In parallel mode it is a divided clock, at one quarter or one eighth of the line rate, whose rising edge marks each word load.

A remote-loopback control replaces all framer data with the received serial stream, so the far end sees its own data again. While loopback is active the transmit timing reference is reported as the recovered receive clock. That reference is also selected whenever the hub select is low. The block also reports whether a request for analog local loopback may take effect. This is allowed only with hub select high and remote loopback off.

Mode and loopback inputs are taken only at word boundaries, so a partial word is never sent. The parallel word is shifted out MSB first.

Top module: `txser_top`

## Requirements
- R1: With par_sel_i low and rloop_i low (serial mode, word length 1), line_o after each rising clk_i edge equals ser_data_i sampled at that edge. tx_clk_o is clk_i itself.
- R2: With par_sel_i high and wide_sel_i high (8-bit mode), par_data_i is sampled at a word-load edge. Bits 7 down to 0 then appear on line_o in the 8 cycles that follow, one per cycle.
- R3: With par_sel_i high and wide_sel_i low (4-bit mode), bits 3 down to 0 of par_data_i appear on line_o in the 4 cycles after the load edge. Bits 7 to 4 have no effect on line_o.
- R4: In 4-bit or 8-bit mode, tx_clk_o is high during the first half of each word's cycles and low during the second half. Its rising edge coincides with the word-load edge, so its period is 4 or 8 bit clocks.
- R5: With rloop_i high (word length 1), line_o after each edge equals rx_data_i sampled at that edge. ser_data_i and par_data_i have no effect, and tx_clk_o is clk_i.
- R6: After each word boundary, ref_recov_o is high when remote loopback is active or hub_sel_i was low, and low otherwise.
- R7: After each word boundary, lloop_en_o is high only when lloop_req_i and hub_sel_i were high and rloop_i was low.
- R8: par_sel_i, wide_sel_i, rloop_i, hub_sel_i and lloop_req_i are sampled only at the last bit of the current word. A change made mid-word does not alter the word being sent.
- R9: While rst_ni is low, line_o, ref_recov_o and lloop_en_o are low and the block is in serial mode. The first load happens at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line-rate bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_sel_i | input | 1 | 1 = parallel framer interface, 0 = serial |
| wide_sel_i | input | 1 | In parallel mode: 1 = 8-bit word, 0 = 4-bit word |
| rloop_i | input | 1 | Remote loopback: send received data instead of framer data |
| hub_sel_i | input | 1 | 1 = local reference for transmit timing, 0 = recovered clock |
| lloop_req_i | input | 1 | Request for analog local loopback |
| ser_data_i | input | 1 | Serial framer data |
| par_data_i | input | WORD_W | Parallel framer data, MSB sent first |
| rx_data_i | input | 1 | Received serial data, used in remote loopback |
| line_o | output | 1 | Serial NRZ line data |
| tx_clk_o | output | 1 | Capture clock driven to the framer |
| ref_recov_o | output | 1 | Transmit timing follows the recovered receive clock |
| lloop_en_o | output | 1 | Local loopback permitted |

## Verification
A wrong bit counter or a stale shift register shows on line_o within one word. The effect is a dropped, repeated or rotated bit, or a word misaligned against the rising edge of tx_clk_o. The bench compares every cycle against a queue of expected bits, so such an error is reported at the first wrong bit. A configuration sampled at the wrong time shows in the first cycle after the missed boundary, as the wrong word length, clock phase or status bit. A leak of upper bits or framer data in 4-bit or loopback mode is caught because random values are driven on those inputs throughout.

// File: rtl/txser_pkg.sv
package txser_pkg;

  typedef enum logic [1:0] {
    FMT_SER  = 2'd0,
    FMT_NIB  = 2'd1,
    FMT_BYTE = 2'd2
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic rloop;
    logic hub;
    logic lloop_req;
  } cfg_t;

endpackage

// File: rtl/txser_mode_ctrl.sv
module txser_mode_ctrl
  import txser_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int NARROW_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_d_i,
  output cfg_t cfg_o,
  output logic last_o,
  output logic div_o,
  output logic ref_o,
  output logic ll_o
);

  localparam int LEN_W = $clog2(WORD_W) + 1;

  localparam cfg_t CFG_RST = '{fmt: FMT_SER, rloop: 1'b0, hub: 1'b0, lloop_req: 1'b0};

  function automatic logic [LEN_W-1:0] len_of(cfg_t c);
    if (c.rloop || c.fmt == FMT_SER) return LEN_W'(1);
    else if (c.fmt == FMT_BYTE)      return LEN_W'(WORD_W);
    else                             return LEN_W'(NARROW_W);
  endfunction

  function automatic logic is_par(cfg_t c);
    return (c.fmt != FMT_SER) && !c.rloop;
  endfunction

  cfg_t             cfg_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_inc;
  logic             div_q, ref_q, ll_q;

  assign len_q   = len_of(cfg_q);
  assign cnt_inc = cnt_q + LEN_W'(1);
  assign last_o  = (cnt_inc == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      cnt_q <= '0;
      div_q <= 1'b0;
      ref_q <= 1'b0;
      ll_q  <= 1'b0;
    end else if (last_o) begin
      cfg_q <= cfg_d_i;
      cnt_q <= '0;
      div_q <= is_par(cfg_d_i);
      ref_q <= cfg_d_i.rloop || !cfg_d_i.hub;
      ll_q  <= cfg_d_i.lloop_req && cfg_d_i.hub && !cfg_d_i.rloop;
    end else begin
      cnt_q <= cnt_inc;
      div_q <= is_par(cfg_q) && (cnt_inc < (len_q >> 1));
    end
  end

  assign cfg_o = cfg_q;
  assign div_o = div_q;
  assign ref_o = ref_q;
  assign ll_o  = ll_q;

endmodule

// File: rtl/txser_word_mux.sv
module txser_word_mux
  import txser_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int NARROW_W = 4
) (
  input  cfg_t              cfg_i,
  input  logic              ser_data_i,
  input  logic [WORD_W-1:0] par_data_i,
  input  logic              rx_data_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int PAD_W = WORD_W - NARROW_W;

  logic [WORD_W-1:0] nib_word;
  logic [WORD_W-1:0] ser_word;
  logic [WORD_W-1:0] rx_word;

  // narrow word is left-aligned so its MSB leaves first
  generate
    if (PAD_W > 0) begin : g_pad
      assign nib_word = {par_data_i[NARROW_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign nib_word = par_data_i;
    end
  endgenerate

  assign ser_word = {ser_data_i, {(WORD_W-1){1'b0}}};
  assign rx_word  = {rx_data_i,  {(WORD_W-1){1'b0}}};

  always_comb begin
    if (cfg_i.rloop) begin
      word_o = rx_word;
    end else begin
      unique case (cfg_i.fmt)
        FMT_BYTE: word_o = par_data_i;
        FMT_NIB:  word_o = nib_word;
        default:  word_o = ser_word;
      endcase
    end
  end

endmodule

// File: rtl/txser_shifter.sv
module txser_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              line_o
);

  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= word_i;
    else             sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  assign line_o = sh_q[WORD_W-1];

endmodule

// File: rtl/txser_top.sv
module txser_top
  import txser_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int NARROW_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_sel_i,
  input  logic              wide_sel_i,
  input  logic              rloop_i,
  input  logic              hub_sel_i,
  input  logic              lloop_req_i,
  input  logic              ser_data_i,
  input  logic [WORD_W-1:0] par_data_i,
  input  logic              rx_data_i,
  output logic              line_o,
  output logic              tx_clk_o,
  output logic              ref_recov_o,
  output logic              lloop_en_o
);

  cfg_t              cfg_d, cfg_w;
  logic              last_w, div_w, fast_w;
  logic [WORD_W-1:0] word_w;

  always_comb begin
    cfg_d.fmt       = !par_sel_i ? FMT_SER : (wide_sel_i ? FMT_BYTE : FMT_NIB);
    cfg_d.rloop     = rloop_i;
    cfg_d.hub       = hub_sel_i;
    cfg_d.lloop_req = lloop_req_i;
  end

  txser_mode_ctrl #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_d_i (cfg_d),
    .cfg_o   (cfg_w),
    .last_o  (last_w),
    .div_o   (div_w),
    .ref_o   (ref_recov_o),
    .ll_o    (lloop_en_o)
  );

  txser_word_mux #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_mux (
    .cfg_i      (cfg_d),
    .ser_data_i (ser_data_i),
    .par_data_i (par_data_i),
    .rx_data_i  (rx_data_i),
    .word_o     (word_w)
  );

  txser_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (last_w),
    .word_i (word_w),
    .line_o (line_o)
  );

  // one-bit words use the bit clock itself as capture clock
  assign fast_w   = (cfg_w.fmt == FMT_SER) || cfg_w.rloop;
  assign tx_clk_o = fast_w ? clk_i : div_w;

endmodule

// File: rtl/txser_chk.sv
module txser_chk
  import txser_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int NARROW_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_data_i,
  input logic [WORD_W-1:0] par_data_i,
  input logic              rx_data_i,
  input logic              line_o,
  input logic              tx_clk_o,
  input logic              ref_recov_o,
  input logic              lloop_en_o,
  input cfg_t              cfg_w,
  input logic              last_w
);

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_SER_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(last_w) && cfg_w.fmt == FMT_SER && !cfg_w.rloop
    |-> line_o == $past(ser_data_i)); // R1

  AST_BYTE_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(last_w) && cfg_w.fmt == FMT_BYTE && !cfg_w.rloop
    |-> line_o == $past(par_data_i[WORD_W-1])); // R2

  AST_NIB_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(last_w) && cfg_w.fmt == FMT_NIB && !cfg_w.rloop
    |-> line_o == $past(par_data_i[NARROW_W-1])); // R3

  AST_TXCLK_HIGH_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(last_w) && cfg_w.fmt != FMT_SER && !cfg_w.rloop
    |-> tx_clk_o); // R4

  AST_TXCLK_LOW_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_w && cfg_w.fmt != FMT_SER && !cfg_w.rloop |-> !tx_clk_o); // R4

  AST_LOOP_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && cfg_w.rloop |-> line_o == $past(rx_data_i)); // R5

  AST_LOOP_REF_RECOV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_w.rloop |-> ref_recov_o); // R6

  AST_LLOOP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lloop_en_o |-> cfg_w.hub && !cfg_w.rloop); // R7

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_w |=> $stable(cfg_w)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !line_o && !ref_recov_o && !lloop_en_o); // R9

endmodule

bind txser_top txser_chk #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_data_i  (ser_data_i),
  .par_data_i  (par_data_i),
  .rx_data_i   (rx_data_i),
  .line_o      (line_o),
  .tx_clk_o    (tx_clk_o),
  .ref_recov_o (ref_recov_o),
  .lloop_en_o  (lloop_en_o),
  .cfg_w       (cfg_w),
  .last_w      (last_w)
);

// File: tb/txser_top_tb.sv
`timescale 1ns/1ps
module txser_top_tb;

  localparam int WORD_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              par_sel_i = 1'b0, wide_sel_i = 1'b0, rloop_i = 1'b0;
  logic              hub_sel_i = 1'b0, lloop_req_i = 1'b0;
  logic              ser_data_i = 1'b0, rx_data_i = 1'b0;
  logic [WORD_W-1:0] par_data_i = '0;
  logic              line_o, tx_clk_o, ref_recov_o, lloop_en_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  txser_top #(.WORD_W(WORD_W), .NARROW_W(4)) u_dut (
    .clk_i, .rst_ni, .par_sel_i, .wide_sel_i, .rloop_i, .hub_sel_i,
    .lloop_req_i, .ser_data_i, .par_data_i, .rx_data_i,
    .line_o, .tx_clk_o, .ref_recov_o, .lloop_en_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t act=%0d exp=%0d", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: bit queue plus latched configuration
  bit   q[$];
  int   rem = 0, len = 1, pos = 0;
  bit   m_par = 0, m_wide = 0, m_rl = 0, m_hub = 0, m_lreq = 0, m_valid = 0;
  bit   e_line, e_div, e_ref, e_ll, fast;
  string tag;

  always begin
    @(posedge clk_i);
    #2;
    if (!rst_ni) begin
      rem = 0; q.delete(); m_par = 0; m_rl = 0; m_valid = 0;
      chk(line_o == 1'b0,      "R9 line in reset", line_o, 0);
      chk(ref_recov_o == 1'b0, "R9 ref in reset",  ref_recov_o, 0);
      chk(lloop_en_o == 1'b0,  "R9 lloop in reset", lloop_en_o, 0);
      chk(tx_clk_o == 1'b1,    "R9 serial clock in reset", tx_clk_o, 1);
      #5;
      chk(tx_clk_o == 1'b0,    "R9 serial clock low phase", tx_clk_o, 0);
    end else begin
      if (rem == 0) begin
        m_par = par_sel_i; m_wide = wide_sel_i; m_rl = rloop_i;
        m_hub = hub_sel_i; m_lreq = lloop_req_i; m_valid = 1;
        if (m_rl) begin
          len = 1; q.push_back(rx_data_i);
        end else if (!m_par) begin
          len = 1; q.push_back(ser_data_i);
        end else begin
          len = m_wide ? 8 : 4;
          for (int i = len - 1; i >= 0; i--) q.push_back(par_data_i[i]);
        end
        rem = len;
      end
      pos = len - rem;
      rem--;
      e_line = q.pop_front();
      fast   = m_rl || !m_par;
      e_div  = !fast && (pos < len / 2);
      e_ref  = m_rl || !m_hub;
      e_ll   = m_lreq && m_hub && !m_rl;
      if (pos != 0 && (par_sel_i != m_par || wide_sel_i != m_wide || rloop_i != m_rl))
        tag = "R8 line held mid-word";
      else if (m_rl)  tag = "R5 loopback line";
      else if (!m_par) tag = "R1 serial line";
      else if (m_wide) tag = "R2 byte line";
      else             tag = "R3 nibble line";
      chk(line_o == e_line, tag, line_o, e_line);
      chk(ref_recov_o == e_ref, "R6 timing reference", ref_recov_o, e_ref);
      chk(lloop_en_o == e_ll,   "R7 local loopback gate", lloop_en_o, e_ll);
      if (fast) begin
        chk(tx_clk_o == 1'b1, m_rl ? "R5 capture clock high" : "R1 capture clock high", tx_clk_o, 1);
        #5;
        chk(tx_clk_o == 1'b0, m_rl ? "R5 capture clock low" : "R1 capture clock low", tx_clk_o, 0);
      end else begin
        chk(tx_clk_o == e_div, "R4 word clock phase", tx_clk_o, e_div);
        #5;
        chk(tx_clk_o == e_div, "R4 word clock stable", tx_clk_o, e_div);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk_i);
      ser_data_i = 1'($urandom);
      rx_data_i  = 1'($urandom);
      par_data_i = WORD_W'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    run(40);                                       // R1 serial
    par_sel_i = 1; wide_sel_i = 1; run(83);        // R2, R4, R8
    wide_sel_i = 0; run(61);                       // R3 upper bits random
    hub_sel_i = 1; lloop_req_i = 1; run(30);       // R6, R7
    rloop_i = 1; run(50);                          // R5 with parallel inputs set
    par_sel_i = 0; run(20);                        // R5 with serial inputs set
    rloop_i = 0; par_sel_i = 1; wide_sel_i = 1; run(37);
    lloop_req_i = 0; run(21);
    wide_sel_i = 0; run(3);                        // R8 mid-word switch
    rloop_i = 1; run(5);
    rloop_i = 0; run(30);
    hub_sel_i = 0; lloop_req_i = 1; par_sel_i = 0; run(20);
    @(negedge clk_i); rst_ni = 1'b0;               // R9 reset mid-run
    par_sel_i = 1; wide_sel_i = 1;
    run(3);
    @(negedge clk_i); rst_ni = 1'b1;
    run(45);
    @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog R9 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule